// File: doc/BRIEF.md
# Hashed Page Table Walker

This engine turns a segment-relative effective address into a real address by searching a hashed page table held in ordinary memory. The caller supplies the low 28 bits of the effective address (a 256 MB segment of 4 KB pages), the virtual segment ID taken from the segment descriptor, and whether the access is a store. The walker forms a hash from the segment ID and the page index and reads the eight-entry group that the hash selects. If no entry in that group matches, it reads a second group selected by the bitwise complement of the hash.

When an entry matches, the walker reads the entry's second word and sets its referenced bit. On a store it also sets the changed bit. It writes the word back only if a bit actually changed. It then reports a hit together with the real address. Write permission is granted only on a store hit. A load hit withholds it, so that the first later store to the page walks the table again and marks it changed. Permission checks against key and protection bits are done outside this block.

The table sits at a configurable base address. A mask applied to the scaled hash sets its size. All table traffic goes through a single 32-bit memory port that has at most one access in flight.

Top module: `hash_table_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, and `done`, `memReq` and `hit` are 0.
- R2: The page index is `reqOffs[27:12]`. The primary hash is the 24-bit segment ID XOR the zero-extended page index. The secondary hash is the bitwise complement of the primary hash.
- R3: Entry i of a group is at `tableBase + ((hash << 6) & tableMask) + 8*i`. Its first word is at offset +0 and its second word at +4. Every memory address stays inside `tableBase` plus the bits allowed by `tableMask` and the low 6 bits.
- R4: A first word matches only if all of these hold: bit 31 (valid) is 1; bit 6 (secondary flag) equals the pass (0 primary, 1 secondary); bits 30:7 equal the segment ID; bits 5:0 equal page index bits 15:10.
- R5: Entries are read from entry 0 upward, and the first match ends the search. The secondary group is searched only after all 8 primary entries miss.
- R6: On a hit, bit 8 (referenced) of the second word is set, and on a store bit 7 (changed) is also set. The word is written back only when this changes it, and every write carries bit 8 set.
- R7: When neither group matches, `done` pulses with `hit` = 0 and no memory write takes place.
- R8: On a hit, `realAddr` equals second-word bits 31:12 joined with `reqOffs[11:0]`.
- R9: `writeOk` is 1 after a store hit and 0 after a load hit or a miss.
- R10: `done` is high for exactly one cycle per walk, and `reqReady` is high only while the walker is idle.
- R11: `memReq` is a one-cycle pulse. No new request is issued until `memAck` has answered the previous one, which gives read data on a read and acknowledges a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (taken while reqReady) |
| reqReady | output | 1 | Walker idle |
| reqOffs | input | 28 | Effective address within the segment |
| reqVsid | input | 24 | Virtual segment ID from the segment descriptor |
| reqStore | input | 1 | Access is a store |
| tableBase | input | 32 | Byte address of the hash table |
| tableMask | input | 32 | Mask applied to the scaled hash |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Memory response |
| done | output | 1 | Walk finished (one cycle) |
| hit | output | 1 | Translation found |
| realAddr | output | 32 | Translated real address |
| writeOk | output | 1 | Write permission granted by this walk |

## Verification
Some properties are checked on every cycle. Each memory address is confined to the masked table window. Request and completion strobes are single-cycle. Every write-back has the referenced bit set. The secondary pass begins only once the eighth primary entry has missed. Other behaviour is shown only by the bench's scenarios against its own model of the table search, which checks the real address returned and the number of writes issued. These scenarios cover decoy entries that fail a single field of the match, two matching entries where the lower one must win, hits found only through the complemented hash, complete misses, and loads that find the referenced bit already set.

// File: rtl/htw_pkg.sv
package htw_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int VALID_BIT  = 31;
  localparam int SEC_BIT    = 6;
  localparam int REF_BIT    = 8;
  localparam int CHG_BIT    = 7;
  localparam int API_W      = 6;
  localparam int HI_WORD_OFFS = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic stepEntry;
    logic startSecondary;
    logic selWord1;
    logic capWord1;
  } walkCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic matchNow;
    logic lastEntry;
    logic onSecondary;
    logic needWrite;
  } walkSts_t;
endpackage

// File: rtl/htw_datapath.sv
module htw_datapath
  import htw_pkg::*;
#(
  parameter int VSID_W      = 24,
  parameter int PIDX_W      = 16,
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  walkCtl_t                     ctl,
  output walkSts_t                     sts,
  input  logic [PAGE_SHIFT+PIDX_W-1:0] reqOffs,
  input  logic [VSID_W-1:0]            reqVsid,
  input  logic                         reqStore,
  input  logic [WORD_W-1:0]            tableBase,
  input  logic [WORD_W-1:0]            tableMask,
  input  logic [WORD_W-1:0]            memRdata,
  output logic [WORD_W-1:0]            memAddr,
  output logic [WORD_W-1:0]            memWdata,
  output logic                         hit,
  output logic [WORD_W-1:0]            realAddr,
  output logic                         writeOk
);
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int GROUP_SHIFT = $clog2(ENTRIES * ENTRY_BYTES);
  localparam int VSID_LSB    = SEC_BIT + 1;
  localparam int OFFS_W      = PAGE_SHIFT + PIDX_W;

  logic [OFFS_W-1:0] offsReg;
  logic [VSID_W-1:0] vsidReg;
  logic              storeReg;
  logic [IDX_W-1:0]  entryIdx;
  logic              secPass;
  logic [WORD_W-1:0] word1Reg;
  logic              hitReg;
  logic [WORD_W-1:0] raReg;
  logic              wokReg;

  logic [PIDX_W-1:0] pageIdx;
  logic [VSID_W-1:0] primHash;
  logic [VSID_W-1:0] grpHash;
  logic [WORD_W-1:0] grpOff;
  logic [WORD_W-1:0] entryOff;
  logic [API_W-1:0]  apiExp;
  logic [WORD_W-1:0] newW1;

  assign pageIdx  = offsReg[OFFS_W-1:PAGE_SHIFT];
  assign primHash = vsidReg ^ VSID_W'(pageIdx);
  assign grpHash  = secPass ? ~primHash : primHash;
  assign grpOff   = (WORD_W'(grpHash) << GROUP_SHIFT) & tableMask;
  assign entryOff = WORD_W'(entryIdx) * WORD_W'(ENTRY_BYTES);
  assign memAddr  = tableBase + grpOff + entryOff
                  + (ctl.selWord1 ? WORD_W'(HI_WORD_OFFS) : '0);
  assign apiExp   = pageIdx[PIDX_W-1 -: API_W];

  assign sts.matchNow = memRdata[VALID_BIT]
                     && (memRdata[SEC_BIT] == secPass)
                     && (memRdata[VSID_LSB +: VSID_W] == vsidReg)
                     && (memRdata[API_W-1:0] == apiExp);
  assign sts.lastEntry   = (entryIdx == IDX_W'(ENTRIES - 1));
  assign sts.onSecondary = secPass;

  always_comb begin
    newW1 = memRdata;
    newW1[REF_BIT] = 1'b1;
    if (storeReg) newW1[CHG_BIT] = 1'b1;
  end
  assign sts.needWrite = (newW1 != memRdata);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsReg  <= '0;
      vsidReg  <= '0;
      storeReg <= 1'b0;
      entryIdx <= '0;
      secPass  <= 1'b0;
      word1Reg <= '0;
      hitReg   <= 1'b0;
      raReg    <= '0;
      wokReg   <= 1'b0;
    end else begin
      if (ctl.latchReq) begin
        offsReg  <= reqOffs;
        vsidReg  <= reqVsid;
        storeReg <= reqStore;
        entryIdx <= '0;
        secPass  <= 1'b0;
        hitReg   <= 1'b0;
        raReg    <= '0;
        wokReg   <= 1'b0;
      end
      if (ctl.stepEntry) entryIdx <= entryIdx + 1'b1;
      if (ctl.startSecondary) begin
        entryIdx <= '0;
        secPass  <= 1'b1;
      end
      if (ctl.capWord1) begin
        word1Reg <= newW1;
        hitReg   <= 1'b1;
        raReg    <= {memRdata[WORD_W-1:PAGE_SHIFT], offsReg[PAGE_SHIFT-1:0]};
        wokReg   <= storeReg;
      end
    end
  end

  assign memWdata = word1Reg;
  assign hit      = hitReg;
  assign realAddr = raReg;
  assign writeOk  = wokReg;

  // secondary pass only follows a miss on the last primary entry
  assert_secondary_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secPass) |-> ($past(entryIdx) == IDX_W'(ENTRIES - 1)));
endmodule

// File: rtl/htw_ctrl.sv
module htw_ctrl
  import htw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memAck,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     memReq,
  output logic     memWe,
  output logic     reqReady,
  output logic     done
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD0_REQ, S_RD0_WAIT, S_RD1_REQ, S_RD1_WAIT, S_WR_REQ, S_WR_WAIT, S_FINISH
  } walkState_t;

  walkState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    reqReady  = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          nextState    = S_RD0_REQ;
        end
      end
      S_RD0_REQ: begin
        memReq    = 1'b1;
        nextState = S_RD0_WAIT;
      end
      S_RD0_WAIT: begin
        if (memAck) begin
          if (sts.matchNow) begin
            nextState = S_RD1_REQ;
          end else if (!sts.lastEntry) begin
            ctl.stepEntry = 1'b1;
            nextState     = S_RD0_REQ;
          end else if (!sts.onSecondary) begin
            ctl.startSecondary = 1'b1;
            nextState          = S_RD0_REQ;
          end else begin
            nextState = S_FINISH;
          end
        end
      end
      S_RD1_REQ: begin
        memReq       = 1'b1;
        ctl.selWord1 = 1'b1;
        nextState    = S_RD1_WAIT;
      end
      S_RD1_WAIT: begin
        ctl.selWord1 = 1'b1;
        if (memAck) begin
          ctl.capWord1 = 1'b1;
          nextState    = sts.needWrite ? S_WR_REQ : S_FINISH;
        end
      end
      S_WR_REQ: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        ctl.selWord1 = 1'b1;
        nextState    = S_WR_WAIT;
      end
      S_WR_WAIT: begin
        ctl.selWord1 = 1'b1;
        if (memAck) nextState = S_FINISH;
      end
      S_FINISH: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);
endmodule

// File: rtl/hash_table_walker.sv
module hash_table_walker
  import htw_pkg::*;
#(
  parameter int VSID_W      = 24,
  parameter int PIDX_W      = 16,
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [PAGE_SHIFT+PIDX_W-1:0] reqOffs,
  input  logic [VSID_W-1:0]            reqVsid,
  input  logic                         reqStore,
  input  logic [WORD_W-1:0]            tableBase,
  input  logic [WORD_W-1:0]            tableMask,
  output logic                         memReq,
  output logic                         memWe,
  output logic [WORD_W-1:0]            memAddr,
  output logic [WORD_W-1:0]            memWdata,
  input  logic [WORD_W-1:0]            memRdata,
  input  logic                         memAck,
  output logic                         done,
  output logic                         hit,
  output logic [WORD_W-1:0]            realAddr,
  output logic                         writeOk
);
  localparam int LOW_SPAN = ENTRIES * ENTRY_BYTES - 1;

  walkCtl_t ctl;
  walkSts_t sts;

  htw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .sts(sts), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .reqReady(reqReady), .done(done)
  );

  htw_datapath #(
    .VSID_W(VSID_W), .PIDX_W(PIDX_W), .ENTRIES(ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sts(sts),
    .reqOffs(reqOffs), .reqVsid(reqVsid), .reqStore(reqStore),
    .tableBase(tableBase), .tableMask(tableMask), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .hit(hit), .realAddr(realAddr), .writeOk(writeOk)
  );

  assert_addr_in_table_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (((memAddr - tableBase) & ~(tableMask | WORD_W'(LOW_SPAN))) == '0));
  assert_write_has_ref_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> memWdata[REF_BIT]);
endmodule

// File: tb/test_hash_table_walker.sv
module test_hash_table_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] MASK = 32'h0000_3FFF;
  localparam int MEM_WORDS = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [27:0] reqOffs = '0;
  logic [23:0] reqVsid = '0;
  logic        reqStore = 1'b0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        done, hit, writeOk;
  logic [31:0] realAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_table_walker i_hash_table_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOffs(reqOffs), .reqVsid(reqVsid), .reqStore(reqStore),
    .tableBase(BASE), .tableMask(MASK),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck),
    .done(done), .hit(hit), .realAddr(realAddr), .writeOk(writeOk)
  );

  int total = 0;
  int bad = 0;
  int writeCount = 0;
  int overlapCount = 0;
  bit finished = 0;

  logic [31:0] mem [MEM_WORDS];

  typedef struct {
    bit          expHit;
    logic [31:0] expRa;
    bit          expWok;
    int          expWrites;
    int          startWrites;
    int          w1Idx;
    logic [31:0] w1Exp;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int wordIdx(input logic [31:0] a);
    return int'((a - BASE) >> 2);
  endfunction

  function automatic logic [31:0] grpAddr(input logic [23:0] h, input int i);
    return BASE + (({8'h0, h} << 6) & MASK) + 32'(i * 8);
  endfunction

  function automatic logic [31:0] mkW0(input bit v, input logic [23:0] vsid,
                                       input bit sec, input logic [5:0] api);
    return {v, vsid, sec, api};
  endfunction

  function automatic logic [23:0] hashOf(input logic [23:0] vsid, input logic [27:0] offs);
    return vsid ^ {8'h0, offs[27:12]};
  endfunction

  task automatic putEntry(input logic [23:0] h, input int i,
                          input logic [31:0] w0, input logic [31:0] w1);
    mem[wordIdx(grpAddr(h, i))]     = w0;
    mem[wordIdx(grpAddr(h, i)) + 1] = w1;
  endtask

  task automatic clearMem();
    for (int k = 0; k < MEM_WORDS; k++) mem[k] = '0;
  endtask

  // reference search built from the requirements
  function automatic expItem_t model(input logic [27:0] offs, input logic [23:0] vsid,
                                     input bit st, input string tag);
    expItem_t it;
    logic [23:0] h, hh;
    logic [31:0] w0, w1, nw;
    bit found;
    int idx;
    found = 0;
    it.expHit = 0; it.expRa = '0; it.expWok = 0; it.expWrites = 0;
    it.w1Idx = -1; it.w1Exp = '0; it.tag = tag; it.startWrites = 0;
    h = hashOf(vsid, offs);
    for (int p = 0; p < 2; p++) begin
      hh = (p == 1) ? ~h : h;
      for (int i = 0; i < 8; i++) begin
        idx = wordIdx(grpAddr(hh, i));
        w0 = mem[idx];
        if (!found && w0[31] && (w0[6] == p[0]) && (w0[30:7] == vsid)
            && (w0[5:0] == offs[27:22])) begin
          found = 1;
          w1 = mem[idx + 1];
          nw = w1 | 32'h100 | (st ? 32'h80 : 32'h0);
          it.expHit = 1;
          it.expRa = {w1[31:12], offs[11:0]};
          it.expWok = st;
          it.expWrites = (nw != w1) ? 1 : 0;
          it.w1Idx = idx + 1;
          it.w1Exp = nw;
        end
      end
    end
    return it;
  endfunction

  // memory model with rotating latency
  initial begin
    int pendIdx;
    int cnt;
    int latSel;
    bit pending;
    pending = 0; cnt = 0; latSel = 0; pendIdx = 0;
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (pending) begin
        if (memReq) overlapCount++;
        if (cnt == 0) begin
          memAck = 1'b1;
          memRdata = mem[pendIdx];
          pending = 0;
        end else cnt--;
      end else if (memReq && rstN) begin
        pendIdx = wordIdx(memAddr);
        if (memWe) begin
          mem[pendIdx] = memWdata;
          writeCount++;
        end
        pending = 1;
        cnt = latSel;
        latSel = (latSel + 1) % 3;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      if (done && rstN) begin
        if (expQ.size() == 0) begin
          total++; bad++;
          $display("FAIL R10 unexpected done: actual=1 expected=0");
        end else begin
          it = expQ.pop_front();
          check("R7", {it.tag, " hit"}, 32'(hit), 32'(it.expHit));
          check("R8", {it.tag, " realAddr"}, realAddr, it.expRa);
          check("R9", {it.tag, " writeOk"}, 32'(writeOk), 32'(it.expWok));
          check("R6", {it.tag, " writes"}, 32'(writeCount - it.startWrites), 32'(it.expWrites));
          if (it.w1Idx >= 0)
            check("R6", {it.tag, " word1"}, mem[it.w1Idx], it.w1Exp);
          @(negedge clk);
          check("R10", {it.tag, " done pulse"}, 32'(done), 32'h0);
        end
      end
    end
  end

  task automatic walk(input logic [27:0] offs, input logic [23:0] vsid,
                      input bit st, input string tag);
    expItem_t it;
    it = model(offs, vsid, st, tag);
    it.startWrites = writeCount;
    expQ.push_back(it);
    while (!reqReady) @(negedge clk);
    reqOffs = offs; reqVsid = vsid; reqStore = st; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10", {tag, " busy ready"}, 32'(reqReady), 32'h0);
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] v, h;
    logic [27:0] o;
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ready", 32'(reqReady), 32'h1);
    check("R1", "done", 32'(done), 32'h0);
    check("R1", "memReq", 32'(memReq), 32'h0);
    check("R1", "hit", 32'(hit), 32'h0);

    // R2 R3 primary hit at entry 0, load then load again then store
    v = 24'h000123; o = 28'h4567ABC; h = hashOf(v, o);
    putEntry(h, 0, mkW0(1, v, 0, o[27:22]), 32'hCAFE_B000);
    walk(o, v, 0, "R2 primary load");
    walk(o, v, 0, "R6 load ref already set");
    walk(o, v, 1, "R9 store sets changed");

    // R4 decoys failing one field each, true match at entry 5
    clearMem();
    v = 24'h0A5A5A; o = 28'h0FF0123; h = hashOf(v, o);
    putEntry(h, 2, mkW0(1, v, 1, o[27:22]), 32'h1111_1000);
    putEntry(h, 3, mkW0(0, v, 0, o[27:22]), 32'h2222_2000);
    putEntry(h, 4, mkW0(1, v, 0, o[27:22] ^ 6'h1), 32'h3333_3000);
    putEntry(h, 1, mkW0(1, v ^ 24'h1, 0, o[27:22]), 32'h4444_4000);
    putEntry(h, 5, mkW0(1, v, 0, o[27:22]), 32'h5555_5000);
    walk(o, v, 1, "R4 decoys");

    // R5 two matches: lower entry wins
    clearMem();
    v = 24'h00BEEF; o = 28'hC0DE777; h = hashOf(v, o);
    putEntry(h, 6, mkW0(1, v, 0, o[27:22]), 32'h6666_6000);
    putEntry(h, 1, mkW0(1, v, 0, o[27:22]), 32'h7777_7000);
    walk(o, v, 0, "R5 first match");

    // R5 secondary-only hit through complemented hash
    clearMem();
    v = 24'h345678; o = 28'h9ABCDEF; h = hashOf(v, o);
    putEntry(h, 3, mkW0(1, v, 1, o[27:22]), 32'h8888_8000);
    putEntry(~h, 7, mkW0(1, v, 1, o[27:22]), 32'h9999_9180);
    walk(o, v, 0, "R5 secondary");
    walk(o, v, 1, "R5 secondary store");

    // R7 full miss: entry in secondary group with primary flag
    clearMem();
    v = 24'h00F00D; o = 28'h1234567; h = hashOf(v, o);
    putEntry(~h, 0, mkW0(1, v, 0, o[27:22]), 32'hAAAA_A000);
    walk(o, v, 1, "R7 miss");

    // R3 hash bits above the mask are dropped
    clearMem();
    v = 24'hFFFF00; o = 28'h00FF321; h = hashOf(v, o);
    putEntry(h, 4, mkW0(1, v, 0, o[27:22]), 32'hBBBB_B080);
    walk(o, v, 0, "R3 masked hash");

    check("R11", "overlapping requests", 32'(overlapCount), 32'h0);
    check("R10", "queue drained", 32'(expQ.size()), 32'h0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule